// File: doc/BRIEF.md
# Context Return Stack with Masked Restore

This block is the hardware return stack of a small nibble-oriented processor. On a subroutine call or an interrupt entry the core raises a push request together with its whole execution context: the 15-bit program counter, the four 4-bit nibbles of the table pointer, the low and high data-bank selectors, the working-register page, the program page, the RAM page, the accumulator and the carry. That is 53 bits per entry, held in 16 entries.

On a return the core raises a pop request with a 7-bit restore mask. The program counter is always handed back. Each other register group is handed back only when its mask bit is set. The stack never reports overflow or underflow. It is a ring with a wrapping pointer, so a push beyond 16 live entries overwrites the oldest one. The popped fields come out one cycle after the request, together with a program-counter load pulse and one restore pulse per selected group. The register-file logic uses those pulses to decide which registers to load.

Top module: `ctx_return_stack`

## Requirements
- R1: After reset `pcRestore`, `restoreStb` and `protoErr` are all 0, and every stack slot holds an all-zero frame.
- R2: A pop presents, one clock after the pop request, exactly the 53-bit frame given by the most recent push that has not yet been popped.
- R3: Frames come back in last-in first-out order. Three pushes A, B, C followed by three pops return C, B, A.
- R4: The stack has 16 slots in a ring. After 17 pushes, the following 16 pops return pushes 17 down to 2, and a 17th pop returns push 17 again, because the pointer wraps.
- R5: A pop with no live entries is not flagged. It returns the slot just below the pointer in ring order, which is an all-zero frame straight after reset.
- R6: Each accepted pop drives `pcRestore` high for exactly one cycle, the cycle in which the popped data is valid. In that same cycle `restoreStb` equals the pop mask. The mask bits select these groups: bit0 the table pointer, bit1 both bank selectors, bit2 the working-register page, bit3 the program page, bit4 the RAM page, bit5 the accumulator, bit6 the carry.
- R7: A pop with mask 0 raises only `pcRestore`. `restoreStb` stays 0.
- R8: A push and a pop requested in the same cycle raise `protoErr` for one cycle in the following cycle. Neither operation is performed: no strobe fires, and the next pop returns the frame that was on top before the conflict.
- R9: In any cycle that does not follow an accepted pop, `pcRestore` and `restoreStb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Push the presented context |
| pushPc | input | 15 | Program counter to save |
| pushTab | input | 16 | Table pointer, four nibbles |
| pushBankLo | input | 4 | Low data-bank selector |
| pushBankHi | input | 2 | High data-bank selector |
| pushWrPage | input | 4 | Working-register page |
| pushRomPage | input | 4 | Program page |
| pushRamPage | input | 3 | RAM page |
| pushAcc | input | 4 | Accumulator |
| pushCarry | input | 1 | Carry flag |
| popReq | input | 1 | Pop the top entry |
| popMask | input | 7 | Groups to restore on this pop |
| popPc | output | 15 | Popped program counter |
| popTab | output | 16 | Popped table pointer |
| popBankLo | output | 4 | Popped low bank |
| popBankHi | output | 2 | Popped high bank |
| popWrPage | output | 4 | Popped working-register page |
| popRomPage | output | 4 | Popped program page |
| popRamPage | output | 3 | Popped RAM page |
| popAcc | output | 4 | Popped accumulator |
| popCarry | output | 1 | Popped carry |
| pcRestore | output | 1 | Program-counter load pulse, marks valid pop data |
| restoreStb | output | 7 | Per-group restore pulses |
| protoErr | output | 1 | Push and pop were requested together |

## Verification
The hardest state to reach from the ports is a ring that has wrapped: the pointer has passed slot 15 and popping continues past the point where live data ends. Only then do overwritten slots and stale slots become visible. A directed sequence of 17 pushes followed by 17 pops reaches this state. A long random mix of pushes, pops and conflicting requests, scored against a ring model in the bench, then drives the pointer across the wrap boundary many times in both directions.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  localparam int STACK_DEPTH = 16;
  localparam int PC_W    = 15;
  localparam int TAB_W   = 16;
  localparam int BLO_W   = 4;
  localparam int BHI_W   = 2;
  localparam int WRP_W   = 4;
  localparam int ROMP_W  = 4;
  localparam int RAMP_W  = 3;
  localparam int ACC_W   = 4;
  localparam int GROUP_N = 7;

  // Field order inside a saved frame, most significant first.
  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [TAB_W-1:0]  tab;
    logic [BHI_W-1:0]  bankHi;
    logic [BLO_W-1:0]  bankLo;
    logic [WRP_W-1:0]  wrPage;
    logic [ROMP_W-1:0] romPage;
    logic [RAMP_W-1:0] ramPage;
    logic [ACC_W-1:0]  acc;
    logic              carry;
  } ctxFrame_t;

  localparam int FRAME_W = $bits(ctxFrame_t);

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } stackStb_t;
endpackage

// File: rtl/ctx_stack_ctrl.sv
module ctx_stack_ctrl
  import ctx_stack_pkg::*;
#(
  parameter int DEPTH  = STACK_DEPTH,
  parameter int MASK_W = GROUP_N,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [MASK_W-1:0] popMask,
  output stackStb_t         stb,
  output logic [PTR_W-1:0]  wrIdx,
  output logic [PTR_W-1:0]  rdIdx,
  output logic              pcRestore,
  output logic [MASK_W-1:0] restoreStb,
  output logic              protoErr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr;
  logic             conflict;

  assign conflict  = pushReq && popReq;
  assign stb.wrEn  = pushReq && !popReq;
  assign stb.rdEn  = popReq && !pushReq;
  assign wrIdx     = ptr;
  assign rdIdx     = (ptr == '0) ? LAST : ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.wrEn) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end else if (stb.rdEn) begin
      ptr <= rdIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcRestore  <= 1'b0;
      restoreStb <= '0;
      protoErr   <= 1'b0;
    end else begin
      pcRestore  <= stb.rdEn;
      restoreStb <= stb.rdEn ? popMask : '0;
      protoErr   <= conflict;
    end
  end
endmodule

// File: rtl/ctx_stack_store.sv
module ctx_stack_store
  import ctx_stack_pkg::*;
#(
  parameter int DEPTH  = STACK_DEPTH,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackStb_t        stb,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  ctxFrame_t        pushFrame,
  output ctxFrame_t        popFrame
);
  ctxFrame_t slots [DEPTH];
  ctxFrame_t rdData;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slots[i] <= '0;
      end else if (stb.wrEn && (wrIdx == PTR_W'(i))) begin
        slots[i] <= pushFrame;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (rdIdx == PTR_W'(j)) rdData = slots[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popFrame <= '0;
    end else if (stb.rdEn) begin
      popFrame <= rdData;
    end
  end
endmodule

// File: rtl/ctx_return_stack.sv
module ctx_return_stack
  import ctx_stack_pkg::*;
#(
  parameter int DEPTH = STACK_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic [PC_W-1:0]   pushPc,
  input  logic [TAB_W-1:0]  pushTab,
  input  logic [BLO_W-1:0]  pushBankLo,
  input  logic [BHI_W-1:0]  pushBankHi,
  input  logic [WRP_W-1:0]  pushWrPage,
  input  logic [ROMP_W-1:0] pushRomPage,
  input  logic [RAMP_W-1:0] pushRamPage,
  input  logic [ACC_W-1:0]  pushAcc,
  input  logic              pushCarry,
  input  logic              popReq,
  input  logic [GROUP_N-1:0] popMask,
  output logic [PC_W-1:0]   popPc,
  output logic [TAB_W-1:0]  popTab,
  output logic [BLO_W-1:0]  popBankLo,
  output logic [BHI_W-1:0]  popBankHi,
  output logic [WRP_W-1:0]  popWrPage,
  output logic [ROMP_W-1:0] popRomPage,
  output logic [RAMP_W-1:0] popRamPage,
  output logic [ACC_W-1:0]  popAcc,
  output logic              popCarry,
  output logic              pcRestore,
  output logic [GROUP_N-1:0] restoreStb,
  output logic              protoErr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stackStb_t        stb;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;
  ctxFrame_t        pushFrame;
  ctxFrame_t        popFrame;

  assign pushFrame = '{pc: pushPc, tab: pushTab, bankHi: pushBankHi,
                       bankLo: pushBankLo, wrPage: pushWrPage,
                       romPage: pushRomPage, ramPage: pushRamPage,
                       acc: pushAcc, carry: pushCarry};

  ctx_stack_ctrl #(.DEPTH(DEPTH), .MASK_W(GROUP_N)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pushReq    (pushReq),
    .popReq     (popReq),
    .popMask    (popMask),
    .stb        (stb),
    .wrIdx      (wrIdx),
    .rdIdx      (rdIdx),
    .pcRestore  (pcRestore),
    .restoreStb (restoreStb),
    .protoErr   (protoErr)
  );

  ctx_stack_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .pushFrame (pushFrame),
    .popFrame  (popFrame)
  );

  assign popPc      = popFrame.pc;
  assign popTab     = popFrame.tab;
  assign popBankLo  = popFrame.bankLo;
  assign popBankHi  = popFrame.bankHi;
  assign popWrPage  = popFrame.wrPage;
  assign popRomPage = popFrame.romPage;
  assign popRamPage = popFrame.ramPage;
  assign popAcc     = popFrame.acc;
  assign popCarry   = popFrame.carry;
endmodule

// File: rtl/ctx_stack_checker.sv
module ctx_stack_checker (
  input logic        clk,
  input logic        rstN,
  input logic        pushReq,
  input logic        popReq,
  input logic [6:0]  popMask,
  input logic [14:0] pushPc,
  input logic [14:0] popPc,
  input logic        pcRestore,
  input logic [6:0]  restoreStb,
  input logic        protoErr
);
  // R6: every accepted pop yields a PC load pulse next cycle
  a_r6_pc_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq) |=> pcRestore);

  // R6: group pulses carry the mask of the pop
  a_r6_mask_pass: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq) |=> (restoreStb == $past(popMask)));

  // R7: group pulses never appear without the PC pulse
  a_r7_groups_need_pc: assert property (@(posedge clk) disable iff (!rstN)
    (restoreStb != 7'd0) |-> pcRestore);

  // R8: a conflicting request flags an error and pops nothing
  a_r8_conflict: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> (protoErr && !pcRestore));

  // R9: no pulse without an accepted pop
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(popReq && !pushReq) |=> (!pcRestore && restoreStb == 7'd0));

  // R2: a pop straight after a push returns the pushed PC
  a_r2_push_pop: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq) ##1 (popReq && !pushReq) |=> (popPc == $past(pushPc, 2)));
endmodule

bind ctx_return_stack ctx_stack_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pushReq    (pushReq),
  .popReq     (popReq),
  .popMask    (popMask),
  .pushPc     (pushPc),
  .popPc      (popPc),
  .pcRestore  (pcRestore),
  .restoreStb (restoreStb),
  .protoErr   (protoErr)
);

// File: tb/ctx_return_stack_bench.sv
module ctx_return_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  typedef logic [52:0] frame_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushReq = 1'b0;
  logic        popReq = 1'b0;
  logic [6:0]  popMask = '0;
  frame_t      drv = '0;
  logic [14:0] popPc;
  logic [15:0] popTab;
  logic [3:0]  popBankLo;
  logic [1:0]  popBankHi;
  logic [3:0]  popWrPage;
  logic [3:0]  popRomPage;
  logic [2:0]  popRamPage;
  logic [3:0]  popAcc;
  logic        popCarry;
  logic        pcRestore;
  logic [6:0]  restoreStb;
  logic        protoErr;

  int checks = 0;
  int errors = 0;
  frame_t model [DEPTH];
  int mptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_return_stack u_ctx_return_stack (
    .clk(clk), .rstN(rstN), .pushReq(pushReq),
    .pushPc(drv[52:38]), .pushTab(drv[37:22]), .pushBankHi(drv[21:20]),
    .pushBankLo(drv[19:16]), .pushWrPage(drv[15:12]), .pushRomPage(drv[11:8]),
    .pushRamPage(drv[7:5]), .pushAcc(drv[4:1]), .pushCarry(drv[0]),
    .popReq(popReq), .popMask(popMask),
    .popPc(popPc), .popTab(popTab), .popBankLo(popBankLo), .popBankHi(popBankHi),
    .popWrPage(popWrPage), .popRomPage(popRomPage), .popRamPage(popRamPage),
    .popAcc(popAcc), .popCarry(popCarry), .pcRestore(pcRestore),
    .restoreStb(restoreStb), .protoErr(protoErr)
  );

  function automatic frame_t randFrame();
    logic [63:0] r = {$urandom(), $urandom()};
    return r[52:0];
  endfunction

  function automatic int below(int p);
    return (p == 0) ? DEPTH - 1 : p - 1;
  endfunction

  function automatic frame_t gotFrame();
    return {popPc, popTab, popBankHi, popBankLo, popWrPage, popRomPage,
            popRamPage, popAcc, popCarry};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doPush(frame_t f);
    @(negedge clk);
    pushReq = 1'b1; drv = f;
    @(posedge clk); #1;
    check("R9 no pulse on push", {pcRestore, restoreStb, protoErr}, 0);
    model[mptr] = f;
    mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
    @(negedge clk);
    pushReq = 1'b0;
  endtask

  task automatic doPop(logic [6:0] m, string req);
    frame_t exp;
    exp = model[below(mptr)];
    @(negedge clk);
    popReq = 1'b1; popMask = m;
    @(posedge clk); #1;
    check({req, " popped frame"}, gotFrame(), exp);
    check("R6 pc pulse", pcRestore, 1);
    check("R6 R7 group pulses", restoreStb, m);
    mptr = below(mptr);
    @(negedge clk);
    popReq = 1'b0; popMask = '0;
    @(posedge clk); #1;
    check("R9 pulse ends", {pcRestore, restoreStb}, 0);
  endtask

  task automatic doConflict(frame_t f);
    @(negedge clk);
    pushReq = 1'b1; popReq = 1'b1; drv = f; popMask = 7'h7f;
    @(posedge clk); #1;
    check("R8 error flag", protoErr, 1);
    check("R8 no pop", {pcRestore, restoreStb}, 0);
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0; popMask = '0;
    @(posedge clk); #1;
    check("R8 error one cycle", protoErr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    frame_t a, b, c;
    int op;
    void'($urandom(32'd7391));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {pcRestore, restoreStb, protoErr}, 0);
    @(negedge clk); rstN = 1'b1;

    // R5: pop with nothing live returns a zero frame
    doPop(7'h7f, "R5");
    check("R5 zero frame", gotFrame(), 0);

    // R2 and R7: single push then plain return
    a = randFrame();
    doPush(a);
    doPop(7'h00, "R2 R7");

    // R3: LIFO order
    a = randFrame(); b = randFrame(); c = randFrame();
    doPush(a); doPush(b); doPush(c);
    doPop(7'h01, "R3"); doPop(7'h02, "R3"); doPop(7'h04, "R3");

    // R6: each mask bit alone
    for (int k = 0; k < 7; k++) begin
      doPush(randFrame());
      doPop(7'(1 << k), "R6");
    end

    // R4: wrap after 17 pushes, 17 pops
    for (int k = 0; k < DEPTH + 1; k++) doPush(randFrame());
    for (int k = 0; k < DEPTH + 1; k++) doPop(7'(k), "R4");

    // R8: conflict leaves the top unchanged
    a = randFrame();
    doPush(a);
    doConflict(randFrame());
    doPop(7'h7f, "R8");

    // Random mix scored against the ring model
    for (int n = 0; n < 400; n++) begin
      op = $urandom_range(0, 9);
      if (op < 5) doPush(randFrame());
      else if (op < 9) doPop(7'($urandom_range(0, 127)), "R2 R3 R4");
      else doConflict(randFrame());
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule